// File: doc/BRIEF.md
# DTMF Burst Tone Pair Generator

This block turns a 4-bit keypad code into two streams of stepped-sine sample words, one for the row tone of the keypad and one for the column tone. It runs from a 3.579545 MHz reference clock. Each tone is a 32-step sine. The period of each step is a fixed integer number of clocks, so the generated pitches sit slightly off the nominal keypad frequencies: 699.1, 766.2, 847.4 and 948.0 Hz for the rows, and 1215.9, 1331.7, 1471.9 and 1645.0 Hz for the columns. Summing the two streams and filtering them are left to the analog path that follows.

A small controller decides when the tones sound. In burst mode, a key write while idle plays the pair for a timed burst (about 50 ms, or about 100 ms with the long option). A silent pause of the same length follows, and the transmit-buffer-empty flag then rises again. A key written while a burst or its pause is running is held and starts the next burst as soon as the pause ends. In continuous mode, the pair plays for as long as transmit enable is high, using the most recently written key.

Controller states are `ST_IDLE` (silent, waiting), `ST_TONE` (timed burst sounding), `ST_PAUSE` (timed silence) and `ST_CONT` (continuous tone). The transitions are:
- `ST_IDLE` to `ST_TONE` on a key write in burst mode.
- `ST_IDLE` to `ST_CONT` when transmit enable is high in continuous mode.
- `ST_CONT` to `ST_IDLE` when enable falls or burst mode is selected.
- `ST_TONE` to `ST_PAUSE` when the burst count ends.
- `ST_PAUSE` to `ST_TONE` when the pause count ends and a key is held or is being written.
- `ST_PAUSE` to `ST_IDLE` when the pause count ends and no key is held.

Top module: `dtmf_burst_gen`

## Requirements
- R1: The key code selects a keypad row and column as follows. Codes 1 to 9 map to keys 1 to 9 in rows of three (1-3 in row 0, 4-6 in row 1, 7-9 in row 2), with columns 0 to 2 left to right. 4'b1010 is key 0 (row 3, column 1). 4'b1011 is star (row 3, column 0). 4'b1100 is pound (row 3, column 2). 4'b1101, 4'b1110 and 4'b1111 are keys A, B and C (rows 0, 1 and 2, column 3). 4'b0000 is key D (row 3, column 3).
- R2: One sine step lasts 160, 146, 132 or 118 clocks for rows 0 to 3, and 92, 84, 76 or 68 clocks for columns 0 to 3. The first step pulse comes one divisor after the tone starts. Each step pulse is a one-cycle high on `low_step` or `high_step`.
- R3: Each sample is signed 8-bit round(127*sin(2*pi*k/32)), where k is the number of steps since the tone started, modulo 32. Both samples are 0 whenever no tone is sounding, and k restarts from 0 at every tone start.
- R4: In burst mode, a key write while idle starts the tone on the next cycle. The tone lasts BURST_CLKS cycles and is followed by BURST_CLKS silent cycles.
- R5: With `long_burst` high at the start of a burst, both the tone and the pause last 2*BURST_CLKS cycles.
- R6: `tx_empty` is 1 after reset. It goes to 0 the cycle after a burst-mode write, and returns to 1 only when a pause ends with no key held.
- R7: A key written during a tone or pause is held. The next burst starts in the cycle right after the pause ends, and if several keys were written, the latest one is played.
- R8: In continuous mode, the tone sounds from the cycle after `tx_en` is seen high until the cycle after it is seen low. A key write in this mode does not change `tx_empty`.
- R9: `tone_on` is high exactly while a burst tone or a continuous tone is sounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_code | input | 4 | Keypad code, sampled with key_wr |
| key_wr | input | 1 | One-cycle key write strobe |
| burst_mode | input | 1 | 1 = timed bursts, 0 = continuous tone |
| long_burst | input | 1 | Selects the doubled burst and pause length |
| tx_en | input | 1 | Continuous-mode transmit enable |
| low_sample | output | 8 | Signed row-tone sample |
| high_sample | output | 8 | Signed column-tone sample |
| low_step | output | 1 | Pulse when the row sample advances |
| high_step | output | 1 | Pulse when the column sample advances |
| tone_on | output | 1 | Tone pair is sounding |
| tx_empty | output | 1 | No key waiting or being sent |

## Verification
A write or enable change seen at clock edge E puts `tone_on` high after E. The k-th step of a tone lands exactly at edge E+k*divisor. The burst end falls at E+L and `tx_empty` rises at E+2L, where L is the burst length. The driver records E from its own cycle counter and queues each expected step together with the edge it is due on. The monitor then compares both the edge and the sample value whenever a step pulse appears. Level checks on `tone_on` and `tx_empty` are sampled on the falling edge just before and just after each computed boundary edge.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int SAMP_W = 8;
    localparam int DIV_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONT,
        ST_TONE,
        ST_PAUSE
    } burst_state_e;

    // keypad code -> {row, col}
    function automatic logic [3:0] key_rowcol(input logic [3:0] code);
        logic [1:0] r;
        logic [1:0] c;
        int         n;
        n = int'(code);
        if (n >= 1 && n <= 9) begin
            r = 2'((n - 1) / 3);
            c = 2'((n - 1) % 3);
        end else if (n >= 13) begin
            r = 2'(n - 13);
            c = 2'd3;
        end else begin
            r = 2'd3;
            unique case (code)
                4'd10:   c = 2'd1;
                4'd11:   c = 2'd0;
                4'd12:   c = 2'd2;
                default: c = 2'd3;
            endcase
        end
        return {r, c};
    endfunction

    function automatic logic [DIV_W-1:0] row_div(input logic [1:0] r);
        unique case (r)
            2'd0: return DIV_W'(160);
            2'd1: return DIV_W'(146);
            2'd2: return DIV_W'(132);
            default: return DIV_W'(118);
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] col_div(input logic [1:0] c);
        unique case (c)
            2'd0: return DIV_W'(92);
            2'd1: return DIV_W'(84);
            2'd2: return DIV_W'(76);
            default: return DIV_W'(68);
        endcase
    endfunction

    // 32-step sine, quarter wave mirrored
    function automatic logic signed [SAMP_W-1:0] sine32(input logic [4:0] k);
        logic [3:0]        idx;
        logic [SAMP_W-1:0] mag;
        idx = k[3] ? (4'd8 - {1'b0, k[2:0]}) : {1'b0, k[2:0]};
        unique case (idx)
            4'd0: mag = 8'd0;
            4'd1: mag = 8'd25;
            4'd2: mag = 8'd49;
            4'd3: mag = 8'd71;
            4'd4: mag = 8'd90;
            4'd5: mag = 8'd106;
            4'd6: mag = 8'd117;
            4'd7: mag = 8'd125;
            default: mag = 8'd127;
        endcase
        return k[4] ? -$signed(mag) : $signed(mag);
    endfunction

endpackage

// File: rtl/tone_step_osc.sv
module tone_step_osc
    import dtmf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [DIV_W-1:0]         div,
    output logic signed [SAMP_W-1:0] sample,
    output logic                     step
);

    logic [DIV_W-1:0] cnt_q;
    logic [4:0]       phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q   <= '0;
            phase_q <= '0;
            step    <= 1'b0;
        end else if (cnt_q >= div - 1'b1) begin
            cnt_q   <= '0;
            phase_q <= phase_q + 5'd1;
            step    <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            step    <= 1'b0;
        end
    end

    assign sample = sine32(phase_q);

    p_phase_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase_q == 5'd0 && sample == '0));

    p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(en)) |-> (phase_q == $past(phase_q) + 5'd1));

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import dtmf_pkg::*;
#(
    parameter int BURST_CLKS = 178977
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] key_code,
    input  logic       key_wr,
    input  logic       burst_mode,
    input  logic       long_burst,
    input  logic       tx_en,
    output logic [3:0] code,
    output logic       tone_on,
    output logic       tx_empty
);

    localparam int LONG_CLKS = 2 * BURST_CLKS;
    localparam int CNT_W     = $clog2(LONG_CLKS + 1);

    burst_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, lim_q, start_lim;
    logic [3:0]       code_q, pend_code_q;
    logic             pend_q, empty_q;
    logic             wr_burst, last;

    assign wr_burst  = key_wr && burst_mode;
    assign last      = (cnt_q == lim_q - 1'b1);
    assign start_lim = long_burst ? CNT_W'(LONG_CLKS) : CNT_W'(BURST_CLKS);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_burst)                  state_d = ST_TONE;
                      else if (!burst_mode && tx_en) state_d = ST_CONT;
            ST_CONT:  if (burst_mode || !tx_en)      state_d = ST_IDLE;
            ST_TONE:  if (last)                      state_d = ST_PAUSE;
            ST_PAUSE: if (last)                      state_d = (pend_q || key_wr) ? ST_TONE : ST_IDLE;
            default:                                 state_d = ST_IDLE;
        endcase
    end

    // timers, key holding, empty flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            lim_q       <= CNT_W'(BURST_CLKS);
            code_q      <= '0;
            pend_code_q <= '0;
            pend_q      <= 1'b0;
            empty_q     <= 1'b1;
        end else begin
            if (state_q != state_d)
                cnt_q <= '0;
            else if (state_q == ST_TONE || state_q == ST_PAUSE)
                cnt_q <= cnt_q + 1'b1;

            unique case (state_q)
                ST_IDLE: begin
                    if (key_wr) code_q <= key_code;
                    if (wr_burst) begin
                        lim_q   <= start_lim;
                        empty_q <= 1'b0;
                    end
                end
                ST_CONT: begin
                    if (key_wr) code_q <= key_code;
                end
                ST_TONE: begin
                    if (key_wr) begin
                        pend_code_q <= key_code;
                        pend_q      <= 1'b1;
                        empty_q     <= 1'b0;
                    end
                end
                ST_PAUSE: begin
                    if (last) begin
                        if (key_wr || pend_q) begin
                            code_q <= key_wr ? key_code : pend_code_q;
                            pend_q <= 1'b0;
                            lim_q  <= start_lim;
                        end else begin
                            empty_q <= 1'b1;
                        end
                    end else if (key_wr) begin
                        pend_code_q <= key_code;
                        pend_q      <= 1'b1;
                        empty_q     <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tone_on  = (state_q == ST_TONE) || (state_q == ST_CONT);
        tx_empty = empty_q;
        code     = code_q;
    end

    p_count_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TONE || state_q == ST_PAUSE) |-> (cnt_q < lim_q));

    p_write_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_burst) |=> (tone_on && !tx_empty));

    p_empty_after_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> ($past(state_q) == ST_PAUSE && state_q == ST_IDLE));

    p_cont_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONT && !tx_en) |=> !tone_on);

    p_held_key_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE && last && pend_q) |=> (tone_on && !tx_empty));

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
    import dtmf_pkg::*;
#(
    parameter int BURST_CLKS = 178977
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               key_code,
    input  logic                     key_wr,
    input  logic                     burst_mode,
    input  logic                     long_burst,
    input  logic                     tx_en,
    output logic signed [SAMP_W-1:0] low_sample,
    output logic signed [SAMP_W-1:0] high_sample,
    output logic                     low_step,
    output logic                     high_step,
    output logic                     tone_on,
    output logic                     tx_empty
);

    logic [3:0]       act_code;
    logic [3:0]       rowcol;
    logic [DIV_W-1:0] low_div, high_div;

    burst_ctrl #(.BURST_CLKS(BURST_CLKS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_code   (key_code),
        .key_wr     (key_wr),
        .burst_mode (burst_mode),
        .long_burst (long_burst),
        .tx_en      (tx_en),
        .code       (act_code),
        .tone_on    (tone_on),
        .tx_empty   (tx_empty)
    );

    always_comb begin
        rowcol   = key_rowcol(act_code);
        low_div  = row_div(rowcol[3:2]);
        high_div = col_div(rowcol[1:0]);
    end

    tone_step_osc u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tone_on),
        .div    (low_div),
        .sample (low_sample),
        .step   (low_step)
    );

    tone_step_osc u_high (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tone_on),
        .div    (high_div),
        .sample (high_sample),
        .step   (high_step)
    );

    p_silent_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tone_on) |=> (low_sample == '0 && high_sample == '0));

endmodule

// File: tb/test_dtmf_burst_gen.sv
module test_dtmf_burst_gen;

    localparam int B = 600;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        key_code = '0;
    logic              key_wr = 1'b0;
    logic              burst_mode = 1'b1;
    logic              long_burst = 1'b0;
    logic              tx_en = 1'b0;
    logic signed [7:0] low_sample, high_sample;
    logic              low_step, high_step, tone_on, tx_empty;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int lq_c[$], lq_v[$], hq_c[$], hq_v[$];

    int row_of[16] = '{3,0,0,0,1,1,1,2,2,2,3,3,3,0,1,2};
    int col_of[16] = '{3,0,1,2,0,1,2,0,1,2,1,0,2,3,3,3};
    int ldiv[4] = '{160,146,132,118};
    int hdiv[4] = '{92,84,76,68};

    dtmf_burst_gen #(.BURST_CLKS(B)) i_dtmf_burst_gen (
        .clk(clk), .rst_n(rst_n), .key_code(key_code), .key_wr(key_wr),
        .burst_mode(burst_mode), .long_burst(long_burst), .tx_en(tx_en),
        .low_sample(low_sample), .high_sample(high_sample),
        .low_step(low_step), .high_step(high_step),
        .tone_on(tone_on), .tx_empty(tx_empty)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sine(int k);
        real s;
        s = 127.0 * $sin(2.0 * 3.14159265358979 * real'(k % 32) / 32.0);
        return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
    endfunction

    // driver side of the scoreboard: queue every expected step
    task automatic push_tone(int code, int start, int len);
        int ld = ldiv[row_of[code]];
        int hd = hdiv[col_of[code]];
        for (int k = 1; k * ld <= len; k++) begin
            lq_c.push_back(start + k * ld);
            lq_v.push_back(exp_sine(k));
        end
        for (int k = 1; k * hd <= len; k++) begin
            hq_c.push_back(start + k * hd);
            hq_v.push_back(exp_sine(k));
        end
    endtask

    task automatic wait_edge(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic wr_key(input logic [3:0] c, output int edge_n);
        key_code = c;
        key_wr   = 1'b1;
        edge_n   = cyc + 1;
        @(negedge clk);
        key_wr   = 1'b0;
    endtask

    // monitor side: pop and compare on each step pulse (R1, R2, R3)
    always @(negedge clk) begin
        if (rst_n) begin
            if (low_step) begin
                if (lq_c.size() == 0) chk("R2 unexpected low step", cyc, -1);
                else begin
                    chk("R1/R2 low step edge", cyc, lq_c.pop_front());
                    chk("R3 low sample", int'(low_sample), lq_v.pop_front());
                end
            end
            if (high_step) begin
                if (hq_c.size() == 0) chk("R2 unexpected high step", cyc, -1);
                else begin
                    chk("R1/R2 high step edge", cyc, hq_c.pop_front());
                    chk("R3 high sample", int'(high_sample), hq_v.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        summary();
    end

    initial begin
        int e, e2, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset tx_empty", int'(tx_empty), 1);
        chk("R9 reset tone_on", int'(tone_on), 0);
        chk("R3 reset low", int'(low_sample), 0);
        chk("R3 reset high", int'(high_sample), 0);

        // key 1 short burst (R4, R6, R9)
        wr_key(4'd1, e);
        push_tone(1, e, B);
        chk("R4 tone starts", int'(tone_on), 1);
        chk("R6 cleared by write", int'(tx_empty), 0);
        wait_edge(e + B - 1);
        chk("R4 last tone cycle", int'(tone_on), 1);
        wait_edge(e + B);
        chk("R4 pause begins", int'(tone_on), 0);
        wait_edge(e + B + 5);
        chk("R3 silent low", int'(low_sample), 0);
        chk("R3 silent high", int'(high_sample), 0);
        wait_edge(e + 2 * B - 1);
        chk("R6 empty held low in pause", int'(tx_empty), 0);
        wait_edge(e + 2 * B);
        chk("R6 empty after pause", int'(tx_empty), 1);

        // key 0 long burst (R5)
        long_burst = 1'b1;
        wr_key(4'b1010, e);
        push_tone(10, e, 2 * B);
        wait_edge(e + B + 10);
        chk("R5 tone past short length", int'(tone_on), 1);
        wait_edge(e + 2 * B);
        chk("R5 long tone ends", int'(tone_on), 0);
        wait_edge(e + 4 * B - 1);
        chk("R5 long pause", int'(tx_empty), 0);
        wait_edge(e + 4 * B);
        chk("R5 empty after long pause", int'(tx_empty), 1);
        long_burst = 1'b0;

        // key A with writes held during tone and pause (R7)
        wr_key(4'b1101, e);
        push_tone(13, e, B);
        wait_edge(e + 99);
        wr_key(4'd5, w);
        wait_edge(e + B + 49);
        wr_key(4'd9, w);
        e2 = e + 2 * B;
        push_tone(9, e2, B);
        wait_edge(e2 - 1);
        chk("R7 silent before restart", int'(tone_on), 0);
        wait_edge(e2);
        chk("R7 restart at pause end", int'(tone_on), 1);
        chk("R7 empty stays low", int'(tx_empty), 0);
        wait_edge(e2 + 2 * B);
        chk("R6 empty after second burst", int'(tx_empty), 1);

        // continuous mode with pound (R8, R3 wrap)
        burst_mode = 1'b0;
        wr_key(4'b1100, w);
        chk("R8 write leaves tx_empty", int'(tx_empty), 1);
        chk("R8 no tone without enable", int'(tone_on), 0);
        tx_en = 1'b1;
        e = cyc + 1;
        push_tone(12, e, 2600);
        wait_edge(e);
        chk("R8 tone with enable", int'(tone_on), 1);
        wait_edge(e + 2599);
        tx_en = 1'b0;
        wait_edge(e + 2600);
        chk("R8 tone stops", int'(tone_on), 0);
        wait_edge(e + 2602);
        chk("R3 zero after stop low", int'(low_sample), 0);
        chk("R3 zero after stop high", int'(high_sample), 0);

        // key D then star as short bursts (R1)
        burst_mode = 1'b1;
        wr_key(4'b0000, e);
        push_tone(0, e, B);
        wait_edge(e + 2 * B);
        wr_key(4'b1011, e);
        push_tone(11, e, B);
        wait_edge(e + 2 * B + 2);
        chk("R6 idle at end", int'(tx_empty), 1);

        chk("R2 low queue drained", lq_c.size(), 0);
        chk("R2 high queue drained", hq_c.size(), 0);
        summary();
    end

endmodule